// File: doc/BRIEF.md
# USB Device Command Port

This block is the register-side command port of a USB device serial-interface engine. Software controls the engine through a single 32-bit command word. The word carries a phase selector and either a command code or a data byte. A command phase picks an operation. A write-data phase then delivers its argument, or a read-data phase collects its result. The port keeps the small internal register set that the rest of the engine consumes: device address and enable, configured state, mode byte, connect state, and a stall/disable/feedback/conditional-stall set for each endpoint. It also samples the bus-side status inputs that read commands report.

Two sticky flags in a 10-bit interrupt-status vector tell software how far the handshake has got. The "accepted" flag sets when any phase is taken. The "data ready" flag sets when a read result has been placed on the command-data output. Software clears each flag by writing a one to the matching bit of the clear mask. Buffer clear and buffer validate requests, and per-endpoint interrupt-clear requests, leave the block as one-cycle pulses.

Top module: `usbcmd_engine`

## Requirements
- R1: The command word holds the code or data byte in bits 23:16 and the phase in bits 15:8. Phase 0x05 is command, 0x01 is write data and 0x02 is read data. A word with any other phase, or a command phase with an unknown code, is ignored: no flag sets and the current command stays.
- R2: The accepted flag is interrupt-status bit 4 and the data-ready flag is bit 5. An accepted command or write phase sets bit 4. An accepted read phase sets bits 4 and 5 and loads the command-data output. All other status bits read 0.
- R3: Both flags hold until a clear with the matching mask bit set. A flag being set wins over a clear of that flag in the same cycle.
- R4: A write after command 0xD0 loads the device address from data bits 6:0 and the enable from bit 7. A write after 0xD8 loads the configured bit from data bit 0. A write after 0xF3 loads the 8-bit mode.
- R5: A write after 0xFE sets connect from data bit 0. A read of 0xFE returns bit 0 connect, bit 1 connect-changed, bit 2 suspend (live), bit 3 suspend-changed and bit 4 bus reset. The changed bits and the reset bit latch bus pulses and are cleared by that read, unless a new pulse arrives in the same cycle.
- R6: Command 0x00+n (n below the endpoint count) selects endpoint n. Its read returns bit 0 full, bit 1 stalled (internal state), bit 2 setup seen, bit 3 overwritten, bit 4 NAK sent, bit 5 buffer 1 full, bit 6 buffer 2 full, bit 7 zero. The selected index appears on the select output.
- R7: Command 0x40+n selects endpoint n in the same way. Its read returns the same byte and gives a one-cycle one-hot pulse on bit n of the interrupt-clear output.
- R8: A write after command 0x40+n sets endpoint n's stall from data bit 0, disable from bit 5, rate-feedback mode from bit 6 and conditional stall from bit 7. Writing 0 clears all four. Other endpoints keep their state.
- R9: A read phase whose code differs from the current command, or that follows a command with no read result, is ignored. A write phase after a command that takes no write data is ignored. Neither flag sets and no register changes.
- R10: Reads of 0xF5 alternate between the frame-number low byte and bits 10:8. The high part is captured when the low byte is read. A new command phase restarts with the low byte.
- R11: A read of 0xFF returns the 5-bit error code input (code in bits 3:0, active in bit 4). A read of 0xFB returns the 8-bit error status input, with PID error at bit 0 through toggle error at bit 7.
- R12: Command 0xF2 gives a one-cycle buffer-clear pulse, and its read returns the selected endpoint's overwritten bit in bit 0. Command 0xFA gives a one-cycle buffer-validate pulse. The two pulses never coincide.
- R13: After reset the flags, command data, address, enable, configured, mode, connect and all endpoint state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWord | input | 32 | Command word: byte at 23:16, phase at 15:8 |
| intClrEn | input | 1 | Flag clear strobe |
| intClrMask | input | 10 | Write-one-to-clear mask |
| intStatus | output | 10 | Interrupt status, flags at bits 4 and 5 |
| cmdData | output | 8 | Last read result |
| frameIn | input | 11 | Current frame number from the bus side |
| busSuspend | input | 1 | Suspend level |
| busConnChg | input | 1 | Connect-change pulse |
| busSuspChg | input | 1 | Suspend-change pulse |
| busReset | input | 1 | Bus-reset pulse |
| errCodeIn | input | 5 | Last error code and active bit |
| errStatIn | input | 8 | Error status bits |
| epFullIn | input | NUM_EP | Per-endpoint full flag |
| epSetupIn | input | NUM_EP | Per-endpoint setup-seen flag |
| epOverIn | input | NUM_EP | Per-endpoint overwritten flag |
| epNakIn | input | NUM_EP | Per-endpoint NAK-sent flag |
| epBuf1In | input | NUM_EP | Per-endpoint buffer 1 full |
| epBuf2In | input | NUM_EP | Per-endpoint buffer 2 full |
| devAddr | output | 7 | Device address |
| devEnable | output | 1 | Device enable |
| devConfigured | output | 1 | Configured state |
| devMode | output | 8 | Mode byte |
| devConnect | output | 1 | Connect state |
| epStall | output | NUM_EP | Stall per endpoint |
| epDisable | output | NUM_EP | Disable per endpoint |
| epRateFb | output | NUM_EP | Rate-feedback mode per endpoint |
| epCondStall | output | NUM_EP | Conditional stall per endpoint |
| selEp | output | EP_W | Selected endpoint index |
| bufClrPulse | output | 1 | Buffer clear request |
| bufValidPulse | output | 1 | Buffer validate request |
| epIntClr | output | NUM_EP | One-hot endpoint interrupt-clear request |

## Verification
Every phase is decoded combinationally and takes effect at the clock edge that samples the strobe. Flags, command data, register outputs and the select index are therefore valid straight after that edge. The buffer and interrupt-clear pulses are high for exactly the following cycle. The bench drives each word for one cycle from a falling edge and samples on the next falling edge, which is the only cycle in which the pulses can be seen. Sweeps cover all 256 address bytes, all 256 error-status values, and 64 flag patterns on every endpoint. The expected bytes are built from the bit positions given in the requirements.

// File: rtl/usbcmd_pkg.sv
package usbcmd_pkg;

  localparam int INT_W = 10;
  localparam int FLAG_EMPTY_BIT = 4;
  localparam int FLAG_FULL_BIT = 5;

  localparam logic [7:0] PH_COMMAND = 8'h05;
  localparam logic [7:0] PH_WRITE   = 8'h01;
  localparam logic [7:0] PH_READ    = 8'h02;

  localparam logic [7:0] OP_SET_ADDR   = 8'hD0;
  localparam logic [7:0] OP_CONFIG     = 8'hD8;
  localparam logic [7:0] OP_MODE       = 8'hF3;
  localparam logic [7:0] OP_FRAME      = 8'hF5;
  localparam logic [7:0] OP_DEV_STATUS = 8'hFE;
  localparam logic [7:0] OP_ERR_CODE   = 8'hFF;
  localparam logic [7:0] OP_ERR_STATUS = 8'hFB;
  localparam logic [7:0] OP_CLEAR_BUF  = 8'hF2;
  localparam logic [7:0] OP_VALIDATE   = 8'hFA;
  localparam logic [2:0] OP_SEL_TOP    = 3'b000;
  localparam logic [2:0] OP_SELCLR_TOP = 3'b010;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_FRAME,
    RD_DEVST,
    RD_ERRCODE,
    RD_ERRST,
    RD_CLRBUF,
    RD_SELEP
  } rdSel_e;

  typedef struct packed {
    logic   cmdOk;
    logic   wrOk;
    logic   rdOk;
    logic   setAddr;
    logic   setCfg;
    logic   setMode;
    logic   setDevSt;
    logic   setEpSt;
    logic   loadSel;
    logic   clrBuf;
    logic   validBuf;
    logic   intClr;
    logic   frameHi;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/usbcmd_ctrl.sv
module usbcmd_ctrl
  import usbcmd_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdWrEn,
  input  logic [31:0]     cmdWord,
  output strobe_t         stb,
  output logic [EP_W-1:0] epIdx,
  output logic [7:0]      dataByte
);

  logic [7:0] phase;
  logic [7:0] code;
  logic [7:0] curCmd;
  logic       curValid;
  logic       frameHiNext;
  logic       unusedWordBits;

  assign phase = cmdWord[15:8];
  assign code = cmdWord[23:16];
  assign dataByte = code;
  assign unusedWordBits = ^{cmdWord[31:24], cmdWord[7:0]};

  function automatic logic isSel(input logic [7:0] c);
    return (c[7:5] == OP_SEL_TOP) && (int'(c[4:0]) < NUM_EP);
  endfunction

  function automatic logic isSelClr(input logic [7:0] c);
    return (c[7:5] == OP_SELCLR_TOP) && (int'(c[4:0]) < NUM_EP);
  endfunction

  function automatic logic isWritable(input logic [7:0] c);
    return (c == OP_SET_ADDR) || (c == OP_CONFIG) || (c == OP_MODE) ||
           (c == OP_DEV_STATUS) || isSelClr(c);
  endfunction

  function automatic logic isReadable(input logic [7:0] c);
    return (c == OP_FRAME) || (c == OP_DEV_STATUS) || (c == OP_ERR_CODE) ||
           (c == OP_ERR_STATUS) || (c == OP_CLEAR_BUF) || isSel(c) || isSelClr(c);
  endfunction

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    stb.cmdOk = cmdWrEn && (phase == PH_COMMAND) &&
                (isReadable(code) || isWritable(code) || (code == OP_VALIDATE));
    stb.wrOk = cmdWrEn && (phase == PH_WRITE) && curValid && isWritable(curCmd);
    stb.rdOk = cmdWrEn && (phase == PH_READ) && curValid && (code == curCmd) &&
               isReadable(curCmd);
    stb.setAddr  = stb.wrOk && (curCmd == OP_SET_ADDR);
    stb.setCfg   = stb.wrOk && (curCmd == OP_CONFIG);
    stb.setMode  = stb.wrOk && (curCmd == OP_MODE);
    stb.setDevSt = stb.wrOk && (curCmd == OP_DEV_STATUS);
    stb.setEpSt  = stb.wrOk && isSelClr(curCmd);
    stb.loadSel  = stb.cmdOk && (isSel(code) || isSelClr(code));
    stb.clrBuf   = stb.cmdOk && (code == OP_CLEAR_BUF);
    stb.validBuf = stb.cmdOk && (code == OP_VALIDATE);
    stb.intClr   = stb.rdOk && isSelClr(curCmd);
    stb.frameHi  = frameHiNext;
    if (stb.rdOk) begin
      if (curCmd == OP_FRAME) stb.rdSel = RD_FRAME;
      else if (curCmd == OP_DEV_STATUS) stb.rdSel = RD_DEVST;
      else if (curCmd == OP_ERR_CODE) stb.rdSel = RD_ERRCODE;
      else if (curCmd == OP_ERR_STATUS) stb.rdSel = RD_ERRST;
      else if (curCmd == OP_CLEAR_BUF) stb.rdSel = RD_CLRBUF;
      else stb.rdSel = RD_SELEP;
    end
  end

  assign epIdx = stb.cmdOk ? code[EP_W-1:0] : curCmd[EP_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCmd <= '0;
      curValid <= 1'b0;
      frameHiNext <= 1'b0;
    end else if (stb.cmdOk) begin
      curCmd <= code;
      curValid <= 1'b1;
      frameHiNext <= 1'b0;
    end else if (stb.rdSel == RD_FRAME) begin
      frameHiNext <= ~frameHiNext;
    end
  end

endmodule

// File: rtl/usbcmd_dp.sv
module usbcmd_dp
  import usbcmd_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [EP_W-1:0]   epIdx,
  input  logic [7:0]        dataByte,
  input  logic              intClrEn,
  input  logic [INT_W-1:0]  intClrMask,
  input  logic [10:0]       frameIn,
  input  logic              busSuspend,
  input  logic              busConnChg,
  input  logic              busSuspChg,
  input  logic              busReset,
  input  logic [4:0]        errCodeIn,
  input  logic [7:0]        errStatIn,
  input  logic [NUM_EP-1:0] epFullIn,
  input  logic [NUM_EP-1:0] epSetupIn,
  input  logic [NUM_EP-1:0] epOverIn,
  input  logic [NUM_EP-1:0] epNakIn,
  input  logic [NUM_EP-1:0] epBuf1In,
  input  logic [NUM_EP-1:0] epBuf2In,
  output logic [INT_W-1:0]  intStatus,
  output logic [7:0]        cmdData,
  output logic [6:0]        devAddr,
  output logic              devEnable,
  output logic              devConfigured,
  output logic [7:0]        devMode,
  output logic              devConnect,
  output logic [NUM_EP-1:0] epStall,
  output logic [NUM_EP-1:0] epDisable,
  output logic [NUM_EP-1:0] epRateFb,
  output logic [NUM_EP-1:0] epCondStall,
  output logic [EP_W-1:0]   selEp,
  output logic              bufClrPulse,
  output logic              bufValidPulse,
  output logic [NUM_EP-1:0] epIntClr
);

  logic       flagEmpty;
  logic       flagFull;
  logic       connChg;
  logic       suspChg;
  logic       resetSeen;
  logic [2:0] frameSnap;
  logic [7:0] rdByte;
  logic [7:0] epByte;
  logic       rdDevSt;
  logic       unusedMaskBits;

  assign unusedMaskBits = ^{intClrMask[INT_W-1:FLAG_FULL_BIT+1], intClrMask[FLAG_EMPTY_BIT-1:0]};
  assign rdDevSt = (stb.rdSel == RD_DEVST);

  always_comb begin
    intStatus = '0;
    intStatus[FLAG_EMPTY_BIT] = flagEmpty;
    intStatus[FLAG_FULL_BIT] = flagFull;
  end

  assign epByte = {1'b0, epBuf2In[selEp], epBuf1In[selEp], epNakIn[selEp],
                   epOverIn[selEp], epSetupIn[selEp], epStall[selEp], epFullIn[selEp]};

  always_comb begin
    unique case (stb.rdSel)
      RD_FRAME:   rdByte = stb.frameHi ? {5'b0, frameSnap} : frameIn[7:0];
      RD_DEVST:   rdByte = {3'b0, resetSeen, suspChg, busSuspend, connChg, devConnect};
      RD_ERRCODE: rdByte = {3'b0, errCodeIn};
      RD_ERRST:   rdByte = errStatIn;
      RD_CLRBUF:  rdByte = {7'b0, epOverIn[selEp]};
      RD_SELEP:   rdByte = epByte;
      default:    rdByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagEmpty <= 1'b0;
      flagFull <= 1'b0;
      cmdData <= '0;
      devAddr <= '0;
      devEnable <= 1'b0;
      devConfigured <= 1'b0;
      devMode <= '0;
      devConnect <= 1'b0;
      connChg <= 1'b0;
      suspChg <= 1'b0;
      resetSeen <= 1'b0;
      frameSnap <= '0;
      selEp <= '0;
      bufClrPulse <= 1'b0;
      bufValidPulse <= 1'b0;
      epIntClr <= '0;
    end else begin
      if (stb.cmdOk || stb.wrOk || stb.rdOk) flagEmpty <= 1'b1;
      else if (intClrEn && intClrMask[FLAG_EMPTY_BIT]) flagEmpty <= 1'b0;
      if (stb.rdOk) flagFull <= 1'b1;
      else if (intClrEn && intClrMask[FLAG_FULL_BIT]) flagFull <= 1'b0;

      if (stb.rdOk) cmdData <= rdByte;
      if ((stb.rdSel == RD_FRAME) && !stb.frameHi) frameSnap <= frameIn[10:8];

      if (stb.setAddr) begin
        devAddr <= dataByte[6:0];
        devEnable <= dataByte[7];
      end
      if (stb.setCfg) devConfigured <= dataByte[0];
      if (stb.setMode) devMode <= dataByte;
      if (stb.setDevSt) devConnect <= dataByte[0];

      connChg <= busConnChg | (connChg & ~rdDevSt);
      suspChg <= busSuspChg | (suspChg & ~rdDevSt);
      resetSeen <= busReset | (resetSeen & ~rdDevSt);

      if (stb.loadSel) selEp <= epIdx;
      bufClrPulse <= stb.clrBuf;
      bufValidPulse <= stb.validBuf;
    end
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        epStall[e] <= 1'b0;
        epDisable[e] <= 1'b0;
        epRateFb[e] <= 1'b0;
        epCondStall[e] <= 1'b0;
        epIntClr[e] <= 1'b0;
      end else begin
        if (stb.setEpSt && (int'(epIdx) == e)) begin
          epStall[e] <= dataByte[0];
          epDisable[e] <= dataByte[5];
          epRateFb[e] <= dataByte[6];
          epCondStall[e] <= dataByte[7];
        end
        epIntClr[e] <= stb.intClr && (int'(epIdx) == e);
      end
    end
  end

endmodule

// File: rtl/usbcmd_engine.sv
module usbcmd_engine
  import usbcmd_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [31:0]       cmdWord,
  input  logic              intClrEn,
  input  logic [9:0]        intClrMask,
  output logic [9:0]        intStatus,
  output logic [7:0]        cmdData,
  input  logic [10:0]       frameIn,
  input  logic              busSuspend,
  input  logic              busConnChg,
  input  logic              busSuspChg,
  input  logic              busReset,
  input  logic [4:0]        errCodeIn,
  input  logic [7:0]        errStatIn,
  input  logic [NUM_EP-1:0] epFullIn,
  input  logic [NUM_EP-1:0] epSetupIn,
  input  logic [NUM_EP-1:0] epOverIn,
  input  logic [NUM_EP-1:0] epNakIn,
  input  logic [NUM_EP-1:0] epBuf1In,
  input  logic [NUM_EP-1:0] epBuf2In,
  output logic [6:0]        devAddr,
  output logic              devEnable,
  output logic              devConfigured,
  output logic [7:0]        devMode,
  output logic              devConnect,
  output logic [NUM_EP-1:0] epStall,
  output logic [NUM_EP-1:0] epDisable,
  output logic [NUM_EP-1:0] epRateFb,
  output logic [NUM_EP-1:0] epCondStall,
  output logic [EP_W-1:0]   selEp,
  output logic              bufClrPulse,
  output logic              bufValidPulse,
  output logic [NUM_EP-1:0] epIntClr
);

  strobe_t         stb;
  logic [EP_W-1:0] epIdx;
  logic [7:0]      dataByte;

  usbcmd_ctrl #(.NUM_EP(NUM_EP)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWord(cmdWord),
    .stb(stb), .epIdx(epIdx), .dataByte(dataByte)
  );

  usbcmd_dp #(.NUM_EP(NUM_EP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .epIdx(epIdx), .dataByte(dataByte),
    .intClrEn(intClrEn), .intClrMask(intClrMask), .frameIn(frameIn),
    .busSuspend(busSuspend), .busConnChg(busConnChg), .busSuspChg(busSuspChg),
    .busReset(busReset), .errCodeIn(errCodeIn), .errStatIn(errStatIn),
    .epFullIn(epFullIn), .epSetupIn(epSetupIn), .epOverIn(epOverIn),
    .epNakIn(epNakIn), .epBuf1In(epBuf1In), .epBuf2In(epBuf2In),
    .intStatus(intStatus), .cmdData(cmdData), .devAddr(devAddr),
    .devEnable(devEnable), .devConfigured(devConfigured), .devMode(devMode),
    .devConnect(devConnect), .epStall(epStall), .epDisable(epDisable),
    .epRateFb(epRateFb), .epCondStall(epCondStall), .selEp(selEp),
    .bufClrPulse(bufClrPulse), .bufValidPulse(bufValidPulse), .epIntClr(epIntClr)
  );

endmodule

// File: rtl/usbcmd_engine_chk.sv
module usbcmd_engine_chk #(
  parameter int NUM_EP = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrEn,
  input logic [7:0]        cmdPhase,
  input logic              intClrEn,
  input logic [1:0]        clrFlagMask,
  input logic [9:0]        intStatus,
  input logic [7:0]        cmdData,
  input logic [6:0]        devAddr,
  input logic              devEnable,
  input logic              bufClrPulse,
  input logic              bufValidPulse,
  input logic [NUM_EP-1:0] epIntClr
);

  logic knownPhase;
  assign knownPhase = (cmdPhase == 8'h05) || (cmdPhase == 8'h01) || (cmdPhase == 8'h02);

  p_unused_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[9:6] == 4'b0) && (intStatus[3:0] == 4'b0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWrEn && !intClrEn) |=> $stable(intStatus));

  p_clear_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (intClrEn && clrFlagMask[1] && !cmdWrEn) |=> !intStatus[5]);

  p_bad_phase_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !knownPhase && !intClrEn) |=> ($stable(intStatus) && $stable(cmdData)));

  p_data_only_on_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdWrEn && (cmdPhase == 8'h02)) |=> $stable(cmdData));

  p_full_needs_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[5]) |-> $past(cmdWrEn && (cmdPhase == 8'h02)));

  p_addr_only_on_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdWrEn && (cmdPhase == 8'h01)) |=> $stable({devEnable, devAddr}));

  p_buf_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(bufClrPulse && bufValidPulse));

  p_intclr_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(epIntClr));

endmodule

bind usbcmd_engine usbcmd_engine_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdPhase(cmdWord[15:8]),
  .intClrEn(intClrEn), .clrFlagMask(intClrMask[5:4]), .intStatus(intStatus),
  .cmdData(cmdData), .devAddr(devAddr), .devEnable(devEnable),
  .bufClrPulse(bufClrPulse), .bufValidPulse(bufValidPulse), .epIntClr(epIntClr)
);

// File: tb/test_usbcmd_engine.sv
module test_usbcmd_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 8;
  localparam int EP_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 1'b0;
  logic [31:0] cmdWord = '0;
  logic intClrEn = 1'b0;
  logic [9:0] intClrMask = '0;
  logic [9:0] intStatus;
  logic [7:0] cmdData;
  logic [10:0] frameIn = '0;
  logic busSuspend = 1'b0, busConnChg = 1'b0, busSuspChg = 1'b0, busReset = 1'b0;
  logic [4:0] errCodeIn = '0;
  logic [7:0] errStatIn = '0;
  logic [NUM_EP-1:0] epFullIn = '0, epSetupIn = '0, epOverIn = '0;
  logic [NUM_EP-1:0] epNakIn = '0, epBuf1In = '0, epBuf2In = '0;
  logic [6:0] devAddr;
  logic devEnable, devConfigured, devConnect;
  logic [7:0] devMode;
  logic [NUM_EP-1:0] epStall, epDisable, epRateFb, epCondStall, epIntClr;
  logic [EP_W-1:0] selEp;
  logic bufClrPulse, bufValidPulse;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbcmd_engine #(.NUM_EP(NUM_EP)) i_usbcmd_engine (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWord(cmdWord),
    .intClrEn(intClrEn), .intClrMask(intClrMask), .intStatus(intStatus),
    .cmdData(cmdData), .frameIn(frameIn), .busSuspend(busSuspend),
    .busConnChg(busConnChg), .busSuspChg(busSuspChg), .busReset(busReset),
    .errCodeIn(errCodeIn), .errStatIn(errStatIn), .epFullIn(epFullIn),
    .epSetupIn(epSetupIn), .epOverIn(epOverIn), .epNakIn(epNakIn),
    .epBuf1In(epBuf1In), .epBuf2In(epBuf2In), .devAddr(devAddr),
    .devEnable(devEnable), .devConfigured(devConfigured), .devMode(devMode),
    .devConnect(devConnect), .epStall(epStall), .epDisable(epDisable),
    .epRateFb(epRateFb), .epCondStall(epCondStall), .selEp(selEp),
    .bufClrPulse(bufClrPulse), .bufValidPulse(bufValidPulse), .epIntClr(epIntClr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [7:0] ph, input logic [7:0] code);
    @(negedge clk);
    cmdWrEn = 1'b1;
    cmdWord = {8'h00, code, ph, 8'h00};
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic clearFlags();
    @(negedge clk);
    intClrEn = 1'b1;
    intClrMask = 10'h030;
    @(negedge clk);
    intClrEn = 1'b0;
    intClrMask = '0;
  endtask

  task automatic pulseBus(input logic cc, input logic sc, input logic rs);
    @(negedge clk);
    busConnChg = cc; busSuspChg = sc; busReset = rs;
    @(negedge clk);
    busConnChg = 1'b0; busSuspChg = 1'b0; busReset = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 status", intStatus, 0);
    check("R13 data", cmdData, 0);
    check("R13 addr", {devEnable, devAddr}, 0);
    check("R13 cfg/mode/conn", {devConfigured, devMode, devConnect}, 0);
    check("R13 ep", {epStall, epDisable, epRateFb, epCondStall}, 0);

    // R2 accepted flag on command and write phases
    sendWord(8'h05, 8'hD0);
    check("R2 cmd flag", intStatus, 10'h010);
    clearFlags();
    check("R3 cleared", intStatus, 0);
    sendWord(8'h01, 8'h85);
    check("R2 write flag", intStatus, 10'h010);
    check("R4 addr 85", {devEnable, devAddr}, 8'h85);

    // R4 exhaustive address/enable sweep
    for (int v = 0; v < 256; v++) begin
      sendWord(8'h05, 8'hD0);
      sendWord(8'h01, 8'(v));
      check("R4 addr sweep", {devEnable, devAddr}, v);
    end
    sendWord(8'h05, 8'hD8);
    sendWord(8'h01, 8'hFF);
    check("R4 configure set", devConfigured, 1);
    sendWord(8'h05, 8'hD8);
    sendWord(8'h01, 8'hFE);
    check("R4 configure bit0 only", devConfigured, 0);
    sendWord(8'h05, 8'hF3);
    sendWord(8'h01, 8'hA5);
    check("R4 mode", devMode, 8'hA5);

    // R1 unknown phase and unknown code ignored; current command kept
    sendWord(8'h05, 8'hD0);
    clearFlags();
    sendWord(8'h03, 8'hD0);
    check("R1 unknown phase", intStatus, 0);
    sendWord(8'h05, 8'h77);
    check("R1 unknown code", intStatus, 0);
    sendWord(8'h01, 8'h12);
    check("R1 command kept", {devEnable, devAddr}, 8'h12);

    // R11 error code and status
    errCodeIn = 5'h1A;
    clearFlags();
    sendWord(8'h05, 8'hFF);
    sendWord(8'h02, 8'hFF);
    check("R11 err code", cmdData, 8'h1A);
    check("R2 read flags", intStatus, 10'h030);
    for (int v = 0; v < 256; v++) begin
      errStatIn = 8'(v);
      sendWord(8'h05, 8'hFB);
      sendWord(8'h02, 8'hFB);
      check("R11 err status sweep", cmdData, v);
    end

    // R3 set wins over clear; full flag cleared alone
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWord = {8'h00, 8'hD8, 8'h05, 8'h00};
    intClrEn = 1'b1; intClrMask = 10'h030;
    @(negedge clk);
    cmdWrEn = 1'b0; intClrEn = 1'b0; intClrMask = '0;
    check("R3 set beats clear", intStatus, 10'h010);

    // R9 mismatched read, write after read-only command
    sendWord(8'h05, 8'hFF);
    sendWord(8'h02, 8'hFF);
    clearFlags();
    sendWord(8'h02, 8'hFB);
    check("R9 mismatch flags", intStatus, 0);
    check("R9 mismatch data", cmdData, 8'h1A);
    sendWord(8'h01, 8'h01);
    check("R9 write after read-only", intStatus, 0);
    sendWord(8'h05, 8'h03);
    clearFlags();
    sendWord(8'h01, 8'h01);
    check("R9 write after select", {intStatus, epStall}, 0);
    sendWord(8'h05, 8'hFA);
    clearFlags();
    sendWord(8'h02, 8'hFA);
    check("R9 read after validate", {intStatus, cmdData}, {10'h000, 8'h1A});

    // R10 frame number
    frameIn = 11'h5A3;
    sendWord(8'h05, 8'hF5);
    sendWord(8'h02, 8'hF5);
    check("R10 frame low", cmdData, 8'hA3);
    frameIn = 11'h7FF;
    sendWord(8'h02, 8'hF5);
    check("R10 frame high snapshot", cmdData, 8'h05);
    sendWord(8'h02, 8'hF5);
    check("R10 frame low again", cmdData, 8'hFF);
    frameIn = 11'h123;
    sendWord(8'h05, 8'hF5);
    sendWord(8'h02, 8'hF5);
    check("R10 restart low", cmdData, 8'h23);

    // R5 device status
    sendWord(8'h05, 8'hFE);
    sendWord(8'h01, 8'h01);
    check("R5 connect", devConnect, 1);
    busSuspend = 1'b1;
    pulseBus(1'b1, 1'b0, 1'b1);
    sendWord(8'h05, 8'hFE);
    sendWord(8'h02, 8'hFE);
    check("R5 status read", cmdData, 8'h17);
    sendWord(8'h02, 8'hFE);
    check("R5 read clears", cmdData, 8'h05);
    pulseBus(1'b0, 1'b1, 1'b0);
    busSuspend = 1'b0;
    sendWord(8'h02, 8'hFE);
    check("R5 suspend change", cmdData, 8'h09);

    // R6 select endpoint sweep
    for (int n = 0; n < NUM_EP; n++) begin
      for (int p = 0; p < 64; p++) begin
        logic [5:0] pb;
        pb = 6'(p);
        epFullIn = {NUM_EP{~pb[0]}};  epFullIn[n] = pb[0];
        epSetupIn = {NUM_EP{~pb[1]}}; epSetupIn[n] = pb[1];
        epOverIn = {NUM_EP{~pb[2]}};  epOverIn[n] = pb[2];
        epNakIn = {NUM_EP{~pb[3]}};   epNakIn[n] = pb[3];
        epBuf1In = {NUM_EP{~pb[4]}};  epBuf1In[n] = pb[4];
        epBuf2In = {NUM_EP{~pb[5]}};  epBuf2In[n] = pb[5];
        sendWord(8'h05, 8'(n));
        sendWord(8'h02, 8'(n));
        check("R6 select read", cmdData, {1'b0, pb[5:1], 1'b0, pb[0]});
      end
      check("R6 select index", selEp, n);
    end

    // R8 endpoint status writes
    for (int n = 0; n < NUM_EP; n++) begin
      logic [7:0] v;
      v = (n % 2 == 0) ? 8'hE1 : 8'h41;
      sendWord(8'h05, 8'h40 + 8'(n));
      sendWord(8'h01, v);
      check("R8 ep fields", {epCondStall[n], epRateFb[n], epDisable[n], epStall[n]},
            {v[7], v[6], v[5], v[0]});
    end
    check("R8 stall vector", epStall, {NUM_EP{1'b1}});
    check("R8 disable vector", epDisable, 8'h55);
    sendWord(8'h05, 8'h42);
    sendWord(8'h01, 8'h00);
    check("R8 write zero", {epCondStall[2], epRateFb[2], epDisable[2], epStall[2]}, 0);
    check("R8 neighbours kept", epStall, 8'hFB);

    // R7 select-and-clear with stall visible; R6 stall bit
    epFullIn = '0; epSetupIn = '0; epOverIn = '0; epNakIn = '0; epBuf1In = '0; epBuf2In = '0;
    for (int n = 0; n < NUM_EP; n++) begin
      sendWord(8'h05, 8'h40 + 8'(n));
      sendWord(8'h02, 8'h40 + 8'(n));
      check("R7 clear pulse", epIntClr, 1 << n);
      check("R7 read byte", cmdData, (n == 2) ? 8'h00 : 8'h02);
      @(negedge clk);
      check("R7 pulse one cycle", epIntClr, 0);
    end

    // R12 clear and validate buffer (selected endpoint is NUM_EP-1)
    epOverIn = '0;
    epOverIn[NUM_EP-1] = 1'b1;
    sendWord(8'h05, 8'hF2);
    check("R12 clear pulse", {bufClrPulse, bufValidPulse}, 2'b10);
    sendWord(8'h02, 8'hF2);
    check("R12 overwritten bit", cmdData, 8'h01);
    check("R12 pulse ended", bufClrPulse, 0);
    sendWord(8'h05, 8'hFA);
    check("R12 validate pulse", {bufClrPulse, bufValidPulse}, 2'b01);
    @(negedge clk);
    check("R12 validate one cycle", bufValidPulse, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule